// File: doc/BRIEF.md
# Dual-Controller Graphic LCD Bus Driver

This block connects a host register port to a 128x64 monochrome graphic LCD module whose columns are split between two controllers. Each controller has its own chip-select line and both share one 8-bit parallel bus with an instruction/data select, a read/write select, an enable strobe and a module reset. The host loads a page and a column, then writes a byte to the data register or requests a read-back. The block does the rest: it polls the busy flag of the addressed controller, sends the page and column set instructions, and performs the data access.

Inside, three state machines share the work. The control machine `glcd_ctrl` has the states C_RST, C_IDLE, C_POLL_GO, C_POLL_WAIT, C_OP_GO and C_OP_WAIT. It leaves C_RST after the reset hold. In C_IDLE it takes a host request. It goes from a *_GO state to its *_WAIT state after one cycle. In C_POLL_WAIT it returns to C_POLL_GO while the returned status has bit 7 set, and moves to C_OP_GO once it is clear. In C_OP_WAIT it goes to C_POLL_GO for the next step, or to C_IDLE after the last step. The step machine `glcd_opseq` walks O_IDLE, then O_ON, then O_LINE for each controller during start-up. For host work it walks O_IDLE, O_PAGE, O_COL, then O_WRITE or O_READ, and back to O_IDLE. The strobe machine `glcd_strobe` walks T_IDLE, T_SETUP, T_HIGH and T_HOLD. It samples the bus on the last high cycle and signals completion in T_HOLD.

After system reset the module reset line is held low for a while. Both controllers are then switched on and given start line 0, and only after that does the block take host requests.

Top module: `glcd_bus_driver`

## Requirements
- R1: After system reset, lcd_rst_n stays low for exactly RST_CYC clock cycles. While it is low, E stays low and the status busy bit reads 1.
- R2: Start-up sends four instructions in this order: 0x3F and then 0xC0 to the CS1 controller, and then the same two to the CS2 controller. Busy stays 1 until they are done.
- R3: Before every instruction or data access, the block reads status (RS=0, R/W=1) from the same controller. It repeats that read while bit 7 of the returned byte is 1, and makes the access only once bit 7 is 0.
- R4: A host write to offset 2 stores the 32-bit word. It then sends 0xB8|page[2:0], then 0x40|col[5:0], then a data write (RS=1, R/W=0) of bits 7:0 of the word. The controller latches the byte on the falling edge of E.
- R5: Column bit 6 picks the controller: columns 0 to 63 assert CS1 only, and columns 64 to 127 assert CS2 only. The two chip selects are never high together, and one of them is high whenever E is high.
- R6: E stays high for exactly E_HIGH_CYC cycles. CS, RS, R/W and the output data are stable from the cycle before E rises through the first cycle after E falls.
- R7: When a data write finishes, the column register (offset 1) becomes (col+1) mod 128.
- R8: Writing a word with bit 0 set to offset 3 starts a read: page set, column set, then a data read (RS=1, R/W=1). The sampled byte lands in bits 7:0 of offset 2, with the upper bits cleared, and the column register is unchanged. Writing offset 3 with bit 0 clear starts nothing.
- R9: Bit 0 of offset 3 reads 1 from the cycle after an accepted request until its sequence ends. Host writes made while it is 1 have no effect.
- R10: The data output enable is high only for write accesses (R/W=0), and it is high for every falling edge of E with R/W=0.
- R11: The page register (offset 0) keeps bits 2:0 and the column register (offset 1) keeps bits 6:0. Their other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| host_addr | input | 2 | Register offset: 0 page, 1 column, 2 data, 3 control/status |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data for host_addr, combinational |
| lcd_data_i | input | 8 | Bus value driven by the LCD module |
| lcd_data_o | output | 8 | Bus value driven toward the LCD module |
| lcd_data_oe | output | 1 | Drive enable for lcd_data_o |
| lcd_cs1 | output | 1 | Select for columns 0 to 63, active high |
| lcd_cs2 | output | 1 | Select for columns 64 to 127, active high |
| lcd_rs | output | 1 | 0 instruction/status, 1 display data |
| lcd_rw | output | 1 | 1 read, 0 write |
| lcd_e | output | 1 | Access enable strobe |
| lcd_rst_n | output | 1 | Module reset, active low |

## Verification
The bench builds the block with E_HIGH_CYC=3 and RST_CYC=6. These short strobe and reset windows make every access take only a few dozen cycles, so the bench can write all 128 columns of three pages and read every one back. That sweep crosses the boundary between the two controllers and the wrap of the column counter. The LCD model in the bench holds busy for two status polls after each write, so the repeat path of the busy poll is taken on nearly every access.

// File: rtl/glcd_pkg.sv
package glcd_pkg;
    localparam int PAGE_W  = 3;
    localparam int COL_W   = 7;
    localparam int HALF_W  = COL_W - 1;

    localparam logic [7:0] CMD_DISP_ON  = 8'h3F;
    localparam logic [7:0] CMD_LINE     = 8'hC0;
    localparam logic [7:0] CMD_PAGE     = 8'hB8;
    localparam logic [7:0] CMD_COL      = 8'h40;

    function automatic logic [7:0] make_page(input logic [PAGE_W-1:0] p);
        return CMD_PAGE | {{(8-PAGE_W){1'b0}}, p};
    endfunction

    function automatic logic [7:0] make_col(input logic [HALF_W-1:0] c);
        return CMD_COL | {{(8-HALF_W){1'b0}}, c};
    endfunction

    function automatic logic [7:0] make_line(input logic [5:0] l);
        return CMD_LINE | {2'b00, l};
    endfunction
endpackage

// File: rtl/glcd_strobe.sv
module glcd_strobe #(
    parameter int E_HIGH_CYC = 113
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] bus_in,
    output logic       e,
    output logic       done,
    output logic [7:0] sample
);
    localparam int CW = (E_HIGH_CYC < 2) ? 1 : $clog2(E_HIGH_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(E_HIGH_CYC - 1);

    typedef enum logic [1:0] {T_IDLE, T_SETUP, T_HIGH, T_HOLD} t_state_e;

    t_state_e      state, state_n;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= T_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            T_IDLE:  if (start) state_n = T_SETUP;
            T_SETUP: state_n = T_HIGH;
            T_HIGH:  if (cnt == CNT_LAST) state_n = T_HOLD;
            T_HOLD:  state_n = T_IDLE;
            default: state_n = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sample <= '0;
        end else begin
            if (state == T_HIGH) cnt <= cnt + 1'b1;
            else                 cnt <= '0;
            if (state == T_HIGH && cnt == CNT_LAST) sample <= bus_in;
        end
    end

    always_comb begin
        e    = (state == T_HIGH);
        done = (state == T_HOLD);
    end
endmodule

// File: rtl/glcd_opseq.sv
module glcd_opseq
    import glcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_init,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic              advance,
    input  logic [PAGE_W-1:0] page,
    input  logic [COL_W-1:0]  col,
    input  logic [7:0]        wbyte,
    output logic [1:0]        op_cs,
    output logic              op_rs,
    output logic              op_rw,
    output logic [7:0]        op_byte,
    output logic              op_last,
    output logic              op_wphase,
    output logic              op_rphase
);
    typedef enum logic [2:0] {O_IDLE, O_ON, O_LINE, O_PAGE, O_COL, O_WRITE, O_READ} o_state_e;

    o_state_e state, state_n;
    logic     init_chip;
    logic     rd_mode;
    logic [1:0] host_cs, init_cs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= O_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            O_IDLE:  if (start_init) state_n = O_ON;
                     else if (start_wr || start_rd) state_n = O_PAGE;
            O_ON:    if (advance) state_n = O_LINE;
            O_LINE:  if (advance) state_n = init_chip ? O_IDLE : O_ON;
            O_PAGE:  if (advance) state_n = O_COL;
            O_COL:   if (advance) state_n = rd_mode ? O_READ : O_WRITE;
            O_WRITE: if (advance) state_n = O_IDLE;
            O_READ:  if (advance) state_n = O_IDLE;
            default: state_n = O_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_chip <= 1'b0;
            rd_mode   <= 1'b0;
        end else if (state == O_IDLE) begin
            if (start_init) init_chip <= 1'b0;
            if (start_wr)   rd_mode <= 1'b0;
            else if (start_rd) rd_mode <= 1'b1;
        end else if (state == O_LINE && advance) begin
            init_chip <= 1'b1;
        end
    end

    always_comb begin
        host_cs   = col[COL_W-1] ? 2'b10 : 2'b01;
        init_cs   = init_chip ? 2'b10 : 2'b01;
        op_cs     = 2'b00;
        op_rs     = 1'b0;
        op_rw     = 1'b0;
        op_byte   = 8'h00;
        op_last   = 1'b0;
        op_wphase = 1'b0;
        op_rphase = 1'b0;
        unique case (state)
            O_IDLE: ;
            O_ON: begin
                op_cs   = init_cs;
                op_byte = CMD_DISP_ON;
            end
            O_LINE: begin
                op_cs   = init_cs;
                op_byte = make_line(6'd0);
                op_last = init_chip;
            end
            O_PAGE: begin
                op_cs   = host_cs;
                op_byte = make_page(page);
            end
            O_COL: begin
                op_cs   = host_cs;
                op_byte = make_col(col[HALF_W-1:0]);
            end
            O_WRITE: begin
                op_cs     = host_cs;
                op_rs     = 1'b1;
                op_byte   = wbyte;
                op_last   = 1'b1;
                op_wphase = 1'b1;
            end
            O_READ: begin
                op_cs     = host_cs;
                op_rs     = 1'b1;
                op_rw     = 1'b1;
                op_last   = 1'b1;
                op_rphase = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/glcd_ctrl.sv
module glcd_ctrl #(
    parameter int RST_CYC = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_wr,
    input  logic       req_rd,
    input  logic       strobe_done,
    input  logic [7:0] sample,
    input  logic [1:0] op_cs,
    input  logic       op_rs,
    input  logic       op_rw,
    input  logic [7:0] op_byte,
    input  logic       op_last,
    output logic       strobe_start,
    output logic       start_init,
    output logic       start_wr,
    output logic       start_rd,
    output logic       advance,
    output logic       finish,
    output logic       busy,
    output logic       lcd_rst_n,
    output logic [1:0] bus_cs,
    output logic       bus_rs,
    output logic       bus_rw,
    output logic [7:0] bus_dout,
    output logic       bus_oe
);
    localparam int RCW = $clog2(RST_CYC + 1);
    localparam logic [RCW-1:0] RST_LAST = RCW'(RST_CYC - 1);

    typedef enum logic [2:0] {C_RST, C_IDLE, C_POLL_GO, C_POLL_WAIT, C_OP_GO, C_OP_WAIT} c_state_e;

    c_state_e       state, state_n;
    logic [RCW-1:0] rst_cnt;
    logic           rst_over;

    assign rst_over = (rst_cnt == RST_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= C_RST;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            C_RST:       if (rst_over) state_n = C_POLL_GO;
            C_IDLE:      if (req_wr || req_rd) state_n = C_POLL_GO;
            C_POLL_GO:   state_n = C_POLL_WAIT;
            C_POLL_WAIT: if (strobe_done) state_n = sample[7] ? C_POLL_GO : C_OP_GO;
            C_OP_GO:     state_n = C_OP_WAIT;
            C_OP_WAIT:   if (strobe_done) state_n = op_last ? C_IDLE : C_POLL_GO;
            default:     state_n = C_RST;
        endcase
    end

    always_comb begin
        lcd_rst_n    = (state != C_RST);
        busy         = (state != C_IDLE);
        start_init   = (state == C_RST) && rst_over;
        start_wr     = (state == C_IDLE) && req_wr;
        start_rd     = (state == C_IDLE) && !req_wr && req_rd;
        strobe_start = (state == C_POLL_GO) || (state == C_OP_GO);
        advance      = (state == C_OP_WAIT) && strobe_done;
        finish       = advance && op_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_cnt <= '0;
        else if (state == C_RST && !rst_over) rst_cnt <= rst_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_cs   <= 2'b00;
            bus_rs   <= 1'b0;
            bus_rw   <= 1'b1;
            bus_dout <= 8'h00;
            bus_oe   <= 1'b0;
        end else if (state == C_POLL_GO) begin
            bus_cs <= op_cs;
            bus_rs <= 1'b0;
            bus_rw <= 1'b1;
            bus_oe <= 1'b0;
        end else if (state == C_OP_GO) begin
            bus_cs   <= op_cs;
            bus_rs   <= op_rs;
            bus_rw   <= op_rw;
            bus_dout <= op_byte;
            bus_oe   <= !op_rw;
        end
    end
endmodule

// File: rtl/glcd_regs.sv
module glcd_regs
    import glcd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              busy,
    input  logic              fin_wr,
    input  logic              fin_rd,
    input  logic [7:0]        rd_byte,
    output logic [PAGE_W-1:0] page,
    output logic [COL_W-1:0]  col,
    output logic [7:0]        wbyte,
    output logic              req_wr,
    output logic              req_rd
);
    logic [DATA_W-1:0] data_q;
    logic              accept;

    assign accept = host_wr && !busy;
    assign req_wr = accept && (host_addr == 2'd2);
    assign req_rd = accept && (host_addr == 2'd3) && host_wdata[0];
    assign wbyte  = data_q[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page   <= '0;
            col    <= '0;
            data_q <= '0;
        end else begin
            if (accept && host_addr == 2'd0) page <= host_wdata[PAGE_W-1:0];
            if (accept && host_addr == 2'd1) col  <= host_wdata[COL_W-1:0];
            if (accept && host_addr == 2'd2) data_q <= host_wdata;
            if (fin_wr) col <= col + 1'b1;
            if (fin_rd) data_q <= {{(DATA_W-8){1'b0}}, rd_byte};
        end
    end

    always_comb begin
        unique case (host_addr)
            2'd0:    host_rdata = {{(DATA_W-PAGE_W){1'b0}}, page};
            2'd1:    host_rdata = {{(DATA_W-COL_W){1'b0}}, col};
            2'd2:    host_rdata = data_q;
            default: host_rdata = {{(DATA_W-1){1'b0}}, busy};
        endcase
    end
endmodule

// File: rtl/glcd_bus_driver.sv
module glcd_bus_driver
    import glcd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int E_HIGH_CYC = 113,
    parameter int RST_CYC    = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [7:0]        lcd_data_i,
    output logic [7:0]        lcd_data_o,
    output logic              lcd_data_oe,
    output logic              lcd_cs1,
    output logic              lcd_cs2,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_e,
    output logic              lcd_rst_n
);
    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  col;
    logic [7:0]        wbyte, sample, op_byte;
    logic              req_wr, req_rd, busy;
    logic              strobe_start, strobe_done;
    logic              start_init, start_wr, start_rd, advance, finish;
    logic [1:0]        op_cs, bus_cs;
    logic              op_rs, op_rw, op_last, op_wphase, op_rphase;
    logic              fin_wr, fin_rd;

    assign fin_wr  = finish && op_wphase;
    assign fin_rd  = finish && op_rphase;
    assign lcd_cs1 = bus_cs[0];
    assign lcd_cs2 = bus_cs[1];

    glcd_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
        .fin_wr(fin_wr), .fin_rd(fin_rd), .rd_byte(sample), .page(page),
        .col(col), .wbyte(wbyte), .req_wr(req_wr), .req_rd(req_rd)
    );

    glcd_ctrl #(.RST_CYC(RST_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
        .strobe_done(strobe_done), .sample(sample), .op_cs(op_cs),
        .op_rs(op_rs), .op_rw(op_rw), .op_byte(op_byte), .op_last(op_last),
        .strobe_start(strobe_start), .start_init(start_init),
        .start_wr(start_wr), .start_rd(start_rd), .advance(advance),
        .finish(finish), .busy(busy), .lcd_rst_n(lcd_rst_n), .bus_cs(bus_cs),
        .bus_rs(lcd_rs), .bus_rw(lcd_rw), .bus_dout(lcd_data_o),
        .bus_oe(lcd_data_oe)
    );

    glcd_opseq u_opseq (
        .clk(clk), .rst_n(rst_n), .start_init(start_init), .start_wr(start_wr),
        .start_rd(start_rd), .advance(advance), .page(page), .col(col),
        .wbyte(wbyte), .op_cs(op_cs), .op_rs(op_rs), .op_rw(op_rw),
        .op_byte(op_byte), .op_last(op_last), .op_wphase(op_wphase),
        .op_rphase(op_rphase)
    );

    glcd_strobe #(.E_HIGH_CYC(E_HIGH_CYC)) u_strobe (
        .clk(clk), .rst_n(rst_n), .start(strobe_start), .bus_in(lcd_data_i),
        .e(lcd_e), .done(strobe_done), .sample(sample)
    );
endmodule

// File: rtl/glcd_bus_checker.sv
module glcd_bus_checker #(
    parameter int E_HIGH_CYC = 113
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lcd_e,
    input logic       lcd_cs1,
    input logic       lcd_cs2,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic [7:0] lcd_data_o,
    input logic       lcd_data_oe,
    input logic       lcd_rst_n,
    input logic       busy
);
    logic [31:0] high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     high_cnt <= '0;
        else if (lcd_e) high_cnt <= high_cnt + 1;
        else            high_cnt <= '0;
    end

    assert_rst_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> (busy && !lcd_e));

    assert_e_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> busy);

    assert_cs_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lcd_cs1 && lcd_cs2));

    assert_cs_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> (lcd_cs1 || lcd_cs2));

    assert_e_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (high_cnt == 32'(E_HIGH_CYC)));

    assert_bus_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e || $past(lcd_e)) |-> ($stable(lcd_cs1) && $stable(lcd_cs2) &&
        $stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_data_o)));

    assert_oe_write_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_data_oe |-> !lcd_rw);
endmodule

bind glcd_bus_driver glcd_bus_checker #(.E_HIGH_CYC(E_HIGH_CYC)) u_checker (
    .clk(clk), .rst_n(rst_n), .lcd_e(lcd_e), .lcd_cs1(lcd_cs1),
    .lcd_cs2(lcd_cs2), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_data_o(lcd_data_o), .lcd_data_oe(lcd_data_oe),
    .lcd_rst_n(lcd_rst_n), .busy(busy)
);

// File: tb/glcd_bus_driver_bench.sv
`timescale 1ns/1ps
module glcd_bus_driver_bench;
    localparam int EH = 3;
    localparam int RC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  lcd_data_i, lcd_data_o;
    logic        lcd_data_oe, lcd_cs1, lcd_cs2, lcd_rs, lcd_rw, lcd_e, lcd_rst_n;

    always #2 clk = ~clk;

    glcd_bus_driver #(.DATA_W(32), .E_HIGH_CYC(EH), .RST_CYC(RC)) u_glcd_bus_driver (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .lcd_data_i(lcd_data_i),
        .lcd_data_o(lcd_data_o), .lcd_data_oe(lcd_data_oe), .lcd_cs1(lcd_cs1),
        .lcd_cs2(lcd_cs2), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
        .lcd_rst_n(lcd_rst_n)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // LCD module model: two controllers
    logic [7:0] mem [2][8][64];
    int         busy_left [2];
    logic [2:0] mpage [2];
    logic [5:0] mcol [2];
    logic [8:0] glog [4];
    int         gcount = 0;
    int         accesses = 0, status_reads = 0, busy_polls = 0;
    int         busy_viol = 0, both_cs = 0, e_width_bad = 0, setup_bad = 0, oe_bad = 0;

    always_comb begin
        if (!lcd_rs) lcd_data_i = {(busy_left[lcd_cs2 ? 1 : 0] != 0), 7'b0};
        else         lcd_data_i = mem[lcd_cs2 ? 1 : 0][mpage[lcd_cs2 ? 1 : 0]][mcol[lcd_cs2 ? 1 : 0]];
    end

    logic       p_e = 1'b0, p_cs1 = 1'b0, p_cs2 = 1'b0, p_rs = 1'b0, p_rw = 1'b0;
    logic [7:0] p_do = 8'h00;
    int         hi_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            int ch;
            ch = lcd_cs2 ? 1 : 0;
            if (lcd_data_oe && lcd_rw) oe_bad++;
            if (lcd_cs1 && lcd_cs2) both_cs++;
            if (lcd_e || p_e) begin
                if (lcd_cs1 != p_cs1 || lcd_cs2 != p_cs2 || lcd_rs != p_rs ||
                    lcd_rw != p_rw || lcd_data_o != p_do) setup_bad++;
            end
            if (lcd_e) hi_run++;
            if (p_e && !lcd_e) begin
                if (hi_run != EH) e_width_bad++;
                hi_run = 0;
                if (!lcd_cs1 && !lcd_cs2) both_cs++;
                if (!lcd_rw) begin
                    if (!lcd_data_oe) oe_bad++;
                    if (busy_left[ch] != 0) busy_viol++;
                    accesses++;
                    if (!lcd_rs) begin
                        if (gcount < 4) glog[gcount] = {ch[0], lcd_data_o};
                        gcount++;
                        if ((lcd_data_o & 8'hF8) == 8'hB8) mpage[ch] = lcd_data_o[2:0];
                        else if ((lcd_data_o & 8'hC0) == 8'h40) mcol[ch] = lcd_data_o[5:0];
                    end else begin
                        mem[ch][mpage[ch]][mcol[ch]] = lcd_data_o;
                        mcol[ch] = mcol[ch] + 6'd1;
                    end
                    busy_left[ch] = 2;
                end else if (!lcd_rs) begin
                    status_reads++;
                    if (busy_left[ch] != 0) begin
                        busy_polls++;
                        busy_left[ch]--;
                    end
                end else begin
                    if (busy_left[ch] != 0) busy_viol++;
                    accesses++;
                end
            end
        end
        p_e = lcd_e; p_cs1 = lcd_cs1; p_cs2 = lcd_cs2;
        p_rs = lcd_rs; p_rw = lcd_rw; p_do = lcd_data_o;
    end

    function automatic logic [7:0] pat(input int p, input int c);
        return 8'((p * 37 + c * 5 + 11) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            hr(2'd3, s);
            if (!s[0]) break;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    int pages [3] = '{0, 3, 7};

    initial begin
        logic [31:0] r;
        int lowc, miss, badc;
        for (int c = 0; c < 2; c++) begin
            busy_left[c] = 0; mpage[c] = '0; mcol[c] = '0;
            for (int p = 0; p < 8; p++)
                for (int k = 0; k < 64; k++) mem[c][p][k] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset hold length
        lowc = 0;
        while (!lcd_rst_n && lowc < 1000) begin
            lowc++;
            @(negedge clk);
        end
        check(lowc == RC, "R1 rst low cycles", lowc, RC);
        hr(2'd3, r);
        check(r == 32'd1, "R2 busy during start-up", r, 1);

        wait_idle();
        // R2: start-up instruction order
        check(gcount == 4, "R2 start-up count", gcount, 4);
        check(glog[0] == 9'h03F, "R2 first instr", glog[0], 9'h03F);
        check(glog[1] == 9'h0C0, "R2 second instr", glog[1], 9'h0C0);
        check(glog[2] == 9'h13F, "R2 third instr", glog[2], 9'h13F);
        check(glog[3] == 9'h1C0, "R2 fourth instr", glog[3], 9'h1C0);

        // R11: register widths
        hw(2'd0, 32'hFFFF_FFF5);
        hr(2'd0, r);
        check(r == 32'd5, "R11 page readback", r, 5);
        hw(2'd1, 32'h1234_56C3);
        hr(2'd1, r);
        check(r == 32'h43, "R11 col readback", r, 32'h43);

        // R4 R5 R7: full-column write sweeps
        foreach (pages[i]) begin
            hw(2'd0, pages[i]);
            hw(2'd1, 0);
            badc = 0;
            for (int c = 0; c < 128; c++) begin
                hw(2'd2, {24'hA5C3E1, pat(pages[i], c)});
                wait_idle();
                hr(2'd1, r);
                if (r != 32'((c + 1) % 128)) badc++;
            end
            check(badc == 0, "R7 column increment and wrap", badc, 0);
            miss = 0;
            for (int c = 0; c < 128; c++)
                if (mem[c / 64][pages[i]][c % 64] != pat(pages[i], c)) miss++;
            check(miss == 0, "R4 R5 display bytes by controller", miss, 0);
        end
        miss = 0;
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < 64; k++) if (mem[c][1][k] != 8'h00) miss++;
        check(miss == 0, "R4 unwritten page untouched", miss, 0);

        // R8: read-back sweep
        foreach (pages[i]) begin
            hw(2'd0, pages[i]);
            miss = 0; badc = 0;
            for (int c = 0; c < 128; c++) begin
                hw(2'd1, c);
                hw(2'd3, 32'h1);
                wait_idle();
                hr(2'd2, r);
                if (r != {24'h0, pat(pages[i], c)}) miss++;
                hr(2'd1, r);
                if (r != 32'(c)) badc++;
            end
            check(miss == 0, "R8 read data", miss, 0);
            check(badc == 0, "R8 column unchanged by read", badc, 0);
        end

        // R8: control write with bit 0 clear starts nothing
        lowc = accesses;
        hw(2'd3, 32'h2);
        hr(2'd3, r);
        check(r == 32'd0, "R8 no start when bit0 clear", r, 0);
        check(accesses == lowc, "R8 no bus access", accesses, lowc);

        // R9: busy flag and ignored writes
        hw(2'd0, 2);
        hw(2'd1, 10);
        hw(2'd2, 32'h77);
        hr(2'd3, r);
        check(r == 32'd1, "R9 busy after request", r, 1);
        hw(2'd0, 6);
        hw(2'd2, 32'h99);
        wait_idle();
        hr(2'd0, r);
        check(r == 32'd2, "R9 page write ignored while busy", r, 2);
        hr(2'd1, r);
        check(r == 32'd11, "R9 single write only", r, 11);
        check(mem[0][2][10] == 8'h77, "R9 first byte stored", mem[0][2][10], 8'h77);
        check(mem[0][2][11] == 8'h00, "R9 ignored byte not stored", mem[0][2][11], 0);
        check(mem[0][6][10] == 8'h00, "R9 ignored page not used", mem[0][6][10], 0);

        // Bus-level monitors
        check(busy_viol == 0, "R3 access while controller busy", busy_viol, 0);
        check(busy_polls > 0, "R3 busy poll repeated", busy_polls, 1);
        check(status_reads > accesses, "R3 status read before access", status_reads, accesses);
        check(both_cs == 0, "R5 chip select exclusive", both_cs, 0);
        check(e_width_bad == 0, "R6 E high width", e_width_bad, 0);
        check(setup_bad == 0, "R6 setup and hold", setup_bad, 0);
        check(oe_bad == 0, "R10 output enable", oe_bad, 0);

        finish_run();
    end
endmodule